// File: doc/BRIEF.md
# Bit-Scan and Logarithm Unit

This block examines a single W-bit unsigned word and returns one of five bit-scan results, chosen by a 3-bit operation code. The five results are: the index of the highest set bit together with a found flag, the floor of log2, the ceiling of log2, the number of leading zeros, and the number of trailing zeros. Each operation has its own defined result for an all-zero word. All results except the flag are W bits wide.

One leading-one detector is shared by all five operations. A small mux in front of it feeds the detector either the word, the word minus one (for the ceiling), or the bit-reversed word (for trailing zeros). Every operation is then a light correction of the detector output.

The result, the flag and a valid strobe are registered. A request presented with `in_valid` in one cycle appears on the outputs in the next cycle.

Top module: `bitscan_log_unit`

## Requirements
- R1: With op code 0 (highest set bit), `out_result` is the index of the most significant 1 in the word, with index 0 being the least significant bit. For op codes 0 to 4, `out_flag` is high exactly when at least one input bit is 1.
- R2: With op code 0 and an all-zero word, `out_result` is 0 and `out_flag` is low.
- R3: With op code 1 (floor log2), a nonzero word x gives the k with 2^k <= x < 2^(k+1). An all-zero word gives all ones, which is -1 in W-bit two's complement.
- R4: With op code 2 (ceiling log2), the result is floor log2 of (x-1), plus one, in wrap-around W-bit arithmetic. This gives the smallest k with 2^k >= x, so x = 1 gives 0 and x = 0 gives W.
- R5: With op code 3 (leading zeros), the result is the count of 0 bits above the most significant 1. An all-zero word gives W.
- R6: With op code 4 (trailing zeros), the result is the count of 0 bits below the least significant 1. An all-zero word gives W.
- R7: Op codes 5, 6 and 7 give a result of 0 and a low flag, whatever the word.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock. `out_result` and `out_flag` in that cycle belong to the word and op code sampled at that edge.
- R9: A synchronous active-high reset clears `out_valid`, `out_result` and `out_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_word | input | W | Word to scan |
| op_sel | input | 3 | Operation code (0..4 used, 5..7 reserved) |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_result | output | W | Selected result |
| out_flag | output | 1 | Word had at least one set bit (codes 0..4) |

## Verification
At width 8, every word is applied under every op code, including the reserved ones. This covers each boundary: zero, one, exact powers of two and all ones. It separates floor from ceiling at every power of two and leading from trailing counts on every asymmetric pattern. At width 32, random words are mixed with 0, 1 and all ones. This shows the wrap-around ceiling result and the count of W at full width. Idle cycles are placed at random between requests, which shows that the valid strobe tracks the request one clock later and never more.

// File: rtl/bitscan_log_unit.sv
module bitscan_log_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  input  logic [2:0]   op_sel,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_flag
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] WIDTH_VAL = W'(W);
  localparam logic [W-1:0] TOP_IDX   = W'(W - 1);
  localparam logic [W-1:0] ONE_VAL   = W'(1);

  localparam logic [2:0] OP_HIGHBIT = 3'd0;
  localparam logic [2:0] OP_FLOOR   = 3'd1;
  localparam logic [2:0] OP_CEIL    = 3'd2;
  localparam logic [2:0] OP_LEAD    = 3'd3;
  localparam logic [2:0] OP_TRAIL   = 3'd4;

  logic [W-1:0]  word_dec;
  logic [W-1:0]  word_rev;
  logic [W-1:0]  det_in;
  logic          det_any;
  logic [PW-1:0] det_pos;
  logic [W-1:0]  pos_ext;
  logic [W-1:0]  floor_val;
  logic [W-1:0]  count_val;
  logic [W-1:0]  res_next;
  logic          flag_next;

  assign word_dec = in_word - ONE_VAL;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign word_rev[i] = in_word[W-1-i];
  end

  always_comb begin
    case (op_sel)
      OP_CEIL:  det_in = word_dec;
      OP_TRAIL: det_in = word_rev;
      default:  det_in = in_word;
    endcase
  end

  // shared leading-one detector: highest set index wins
  always_comb begin
    det_pos = '0;
    for (int i = 0; i < W; i++) begin
      if (det_in[i]) det_pos = PW'(i);
    end
  end

  assign det_any   = |det_in;
  assign pos_ext   = W'(det_pos);
  assign floor_val = det_any ? pos_ext : '1;
  assign count_val = det_any ? (TOP_IDX - pos_ext) : WIDTH_VAL;

  always_comb begin
    case (op_sel)
      OP_HIGHBIT: res_next = det_any ? pos_ext : '0;
      OP_FLOOR:   res_next = floor_val;
      OP_CEIL:    res_next = floor_val + ONE_VAL;
      OP_LEAD,
      OP_TRAIL:   res_next = count_val;
      default:    res_next = '0;
    endcase
  end

  assign flag_next = (op_sel <= OP_TRAIL) && (|in_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flag   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_result <= res_next;
      out_flag   <= flag_next;
    end
  end
endmodule

// File: rtl/bitscan_log_unit_chk.sv
module bitscan_log_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_word,
  input logic [2:0]   op_sel,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_flag)); // R9

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid))); // R8

  AST_HIGHBIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel == 3'd0 && in_word == '0)) |-> (out_result == '0 && !out_flag)); // R2

  AST_HIGHBIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel == 3'd0 && $countones(in_word) == 1))
      |-> (out_flag && out_result < W'(W))); // R1

  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel == 3'd1 && in_word == '0)) |-> (out_result == '1)); // R3

  AST_CEIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel == 3'd2 && in_word == '0)) |-> (out_result == W'(W))); // R4

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel == 3'd3 && in_word == '0)) |-> (out_result == W'(W))); // R5

  AST_TRAIL_LSB: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel == 3'd4 && in_word[0])) |-> (out_result == '0)); // R6

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel >= 3'd5)) |-> (out_result == '0 && !out_flag)); // R7
endmodule

bind bitscan_log_unit bitscan_log_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .op_sel(op_sel),
  .out_valid(out_valid), .out_result(out_result), .out_flag(out_flag)
);

// File: tb/test_bitscan_log_unit.sv
`timescale 1ns/1ps
module test_bitscan_log_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        v8 = 1'b0, ov8, fl8;
  logic [7:0]  w8 = '0, r8;
  logic [2:0]  op8 = '0;
  logic        v32 = 1'b0, ov32, fl32;
  logic [31:0] w32 = '0, r32;
  logic [2:0]  op32 = '0;

  bitscan_log_unit #(.W(8)) i_bitscan_log_unit (
    .clk(clk), .rst(rst), .in_valid(v8), .in_word(w8), .op_sel(op8),
    .out_valid(ov8), .out_result(r8), .out_flag(fl8));

  bitscan_log_unit #(.W(32)) i_bitscan_log_unit_w32 (
    .clk(clk), .rst(rst), .in_valid(v32), .in_word(w32), .op_sel(op32),
    .out_valid(ov32), .out_result(r32), .out_flag(fl32));

  // expectations of the previous drive, per width
  bit          pv8 = 0, pf8 = 0, pv32 = 0, pf32 = 0;
  longint unsigned pr8 = 0, pr32 = 0;
  int          pop8 = 0, pop32 = 0;
  longint unsigned px8 = 0, px32 = 0;

  function automatic string req_of(input int op, input longint unsigned x);
    case (op)
      0: return (x == 0) ? "R2" : "R1";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic void model(input int w, input int op, input longint unsigned x,
                                output longint unsigned r, output bit f);
    longint unsigned mask = (64'd1 << w) - 1;
    int hi = -1;
    int lo = -1;
    for (int i = 0; i < w; i++) if (x[i]) begin hi = i; if (lo < 0) lo = i; end
    f = (op <= 4) && (x != 0);
    case (op)
      0: r = (hi < 0) ? 0 : longint'(hi);
      1: r = (hi < 0) ? mask : longint'(hi);
      2: begin
        if (x == 0) r = longint'(w);
        else begin
          int k = 0;
          while ((64'd1 << k) < x) k++;
          r = longint'(k);
        end
      end
      3: r = (hi < 0) ? longint'(w) : longint'(w - 1 - hi);
      4: r = (lo < 0) ? longint'(w) : longint'(lo);
      default: r = 0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_prev();
    check("R8", "w8 out_valid", longint'(ov8), longint'(pv8));
    if (pv8) begin
      check(req_of(pop8, px8), $sformatf("w8 op%0d x=%0h result", pop8, px8), longint'(r8), pr8);
      check(req_of(pop8, px8), $sformatf("w8 op%0d x=%0h flag", pop8, px8), longint'(fl8), longint'(pf8));
    end
    check("R8", "w32 out_valid", longint'(ov32), longint'(pv32));
    if (pv32) begin
      check(req_of(pop32, px32), $sformatf("w32 op%0d x=%0h result", pop32, px32), longint'(r32), pr32);
      check(req_of(pop32, px32), $sformatf("w32 op%0d x=%0h flag", pop32, px32), longint'(fl32), longint'(pf32));
    end
  endtask

  task automatic cycle(input bit a8, input int o8, input longint unsigned x8,
                       input bit a32, input int o32, input longint unsigned x32);
    @(negedge clk);
    compare_prev();
    v8 = a8;  op8 = 3'(o8);  w8 = 8'(x8);
    v32 = a32; op32 = 3'(o32); w32 = 32'(x32);
    pv8 = a8;  pop8 = o8;  px8 = x8 & 64'hFF;
    model(8, o8, px8, pr8, pf8);
    pv32 = a32; pop32 = o32; px32 = x32 & 64'hFFFF_FFFF;
    model(32, o32, px32, pr32, pf32);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    v8 = 1'b1; v32 = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset holds outputs clear even with requests presented
    check("R9", "w8 out_valid in reset", longint'(ov8), 0);
    check("R9", "w8 result in reset", longint'(r8), 0);
    check("R9", "w32 flag in reset", longint'(fl32), 0);
    v8 = 1'b0; v32 = 1'b0;
    rst = 1'b0;
    pv8 = 0; pv32 = 0;
    // exhaustive width 8, with idle gaps
    for (int op = 0; op < 8; op++) begin
      for (int x = 0; x < 256; x++) begin
        if ($urandom % 8 == 0) cycle(1'b0, int'($urandom % 8), $urandom, 1'b0, 0, 0);
        cycle(1'b1, op, longint'(x), 1'b0, 0, 0);
      end
    end
    // width 32: corner words then random words
    for (int op = 0; op < 8; op++) begin
      cycle(1'b0, 0, 0, 1'b1, op, 0);
      cycle(1'b0, 0, 0, 1'b1, op, 1);
      cycle(1'b0, 0, 0, 1'b1, op, 64'hFFFF_FFFF);
      cycle(1'b0, 0, 0, 1'b1, op, 64'h8000_0000);
      for (int n = 0; n < 300; n++) begin
        longint unsigned rx = longint'($urandom);
        if (n % 3 == 1) rx = rx >> ($urandom % 32);
        if (n % 3 == 2) rx = (rx << ($urandom % 32)) & 64'hFFFF_FFFF;
        cycle(1'b0, 0, 0, ($urandom % 5) != 0, op, rx);
      end
    end
    cycle(1'b0, 0, 0, 1'b0, 0, 0);
    cycle(1'b0, 0, 0, 1'b0, 0, 0);
    // R9: synchronous reset mid-stream
    cycle(1'b1, 1, 0, 1'b1, 2, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "w8 out_valid after reset", longint'(ov8), 0);
    check("R9", "w8 result after reset", longint'(r8), 0);
    check("R9", "w32 result after reset", longint'(r32), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule